// File: doc/BRIEF.md
# Compare Register Shadow Update Unit

This unit sits between software register writes and the comparators of a PWM channel. It holds four 16-bit compare values, named SA, RA, SB and RB, in two sets. Software writes a buffered set one byte at a time. The comparators read an active set. The unit decides when the buffered set is copied into the active set.

There are three ways a copy can happen:
- **Free-running copy.** With automatic deferral off and the hold input low, the active set follows the buffer on every clock.
- **Held.** With automatic deferral off and the hold input high, the active set is frozen.
- **Deferred.** With automatic deferral on, the copy waits for the end-of-cycle strobe. It happens only if the last byte written was the RB low byte.

A fifty-percent mode makes the A pair of the active set take its values from the buffered B pair. The A and B timings then match.

Top module: `cmp_shadow`

## Requirements
- R1: After reset, all four active values are zero. The buffered values are also zero.
- R2: A write selects its target through `wr_addr`:
  - `wr_addr[2:1]` picks the register: 0 = SA, 1 = RA, 2 = SB, 3 = RB.
  - `wr_addr[0]` picks the byte: 1 = bits 15:8, 0 = bits 7:0.
  - Writing one byte leaves the other byte of the same value unchanged.
- R3: With `auto_mode` low and `hold` low, each active value equals its buffered value one clock after the buffer changes. `cycle_end` has no effect in this state.
- R4: With `auto_mode` low and `hold` high, the active set does not change, whatever is written and whatever `cycle_end` does. Once `hold` falls, the buffered set reaches the active set on the next clock.
- R5: With `auto_mode` high, a copy happens only on a clock where `cycle_end` is high and the unit is armed.
  - A write to the RB low byte arms the unit.
  - A write to any byte of SA, RA or SB disarms it.
  - A write to the RB high byte leaves the arm state unchanged.
- R6: A deferred copy disarms the unit. A later `cycle_end` with no new RB low-byte write makes no further copy.
- R7: While `auto_mode` is high, `hold` has no effect. Without `cycle_end`, nothing is copied.
- R8: With `fifty` high, every copy loads active SA from buffered SB and active RA from buffered RB. Writes to buffered SA and RA never reach the active set.
- R9: When `cycle_end` and a register write fall on the same clock, the copy decision uses the arm state and buffer contents from before that write. An RB low-byte write on that clock arms the unit for the next `cycle_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Register select in bits 2:1, byte select in bit 0 |
| wr_data | input | 8 | Byte to write |
| hold | input | 1 | Freezes the active set while `auto_mode` is low |
| auto_mode | input | 1 | Defers copies to the end of the cycle |
| fifty | input | 1 | Mirrors the B pair into the A pair on copy |
| cycle_end | input | 1 | End-of-PWM-cycle strobe |
| act_sa | output | 16 | Active SA |
| act_ra | output | 16 | Active RA |
| act_sb | output | 16 | Active SB |
| act_rb | output | 16 | Active RB |

## Verification
A register write and the end-of-cycle strobe can fall on the same clock in deferred mode. That clock decides both the copy and the new arm state. The bench drives the strobe together with an RB low-byte write twice: once while already armed and once while disarmed. In the armed case, the active RB must show the value buffered before the write. In the disarmed case, nothing may move. In both cases, the following strobe alone must deliver the new byte.

// File: rtl/cmp_shadow.sv
module cmp_shadow #(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [BW-1:0] wr_data,
  input  logic         hold,
  input  logic         auto_mode,
  input  logic         fifty,
  input  logic         cycle_end,
  output logic [W-1:0] act_sa,
  output logic [W-1:0] act_ra,
  output logic [W-1:0] act_sb,
  output logic [W-1:0] act_rb
);
  localparam int NREG = 4;
  localparam int RB_IDX = NREG - 1;

  logic [W-1:0] shd [NREG];
  logic         armed;
  logic         xfer;
  logic [1:0]   widx;
  logic         wr_rb_lo, wr_other;

  assign widx     = wr_addr[2:1];
  assign wr_rb_lo = wr_en && widx == 2'(RB_IDX) && !wr_addr[0];
  assign wr_other = wr_en && widx != 2'(RB_IDX);
  assign xfer     = auto_mode ? (cycle_end && armed) : !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) shd[i] <= '0;
    end else if (wr_en) begin
      if (wr_addr[0]) shd[widx][W-1:BW] <= wr_data;
      else            shd[widx][BW-1:0] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              armed <= 1'b0;
    else if (wr_rb_lo)       armed <= 1'b1;
    else if (wr_other)       armed <= 1'b0;
    else if (auto_mode && cycle_end && armed) armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sa <= '0; act_ra <= '0; act_sb <= '0; act_rb <= '0;
    end else if (xfer) begin
      act_sa <= fifty ? shd[2] : shd[0];
      act_ra <= fifty ? shd[3] : shd[1];
      act_sb <= shd[2];
      act_rb <= shd[3];
    end
  end

  assert_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_mode && !hold && !fifty) |=> (act_rb == $past(shd[3]) && act_sa == $past(shd[0])));
  assert_hold_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_mode && hold) |=> $stable({act_sa, act_ra, act_sb, act_rb}));
  assert_auto_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && !(cycle_end && armed)) |=> $stable({act_sa, act_ra, act_sb, act_rb}));
  assert_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && cycle_end && armed && !wr_rb_lo) |=> !armed);
  assert_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && fifty) |=> (act_sa == act_sb && act_ra == act_rb));
endmodule

// File: tb/cmp_shadow_bench.sv
module cmp_shadow_bench;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, hold = 0, auto_mode = 0, fifty = 0, cycle_end = 0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [15:0] act_sa, act_ra, act_sb, act_rb;
  int checks = 0, fails = 0;
  bit done = 0;

  cmp_shadow u_cmp_shadow (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .hold,
    .auto_mode, .fifty, .cycle_end, .act_sa, .act_ra, .act_sb, .act_rb);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(int idx, bit hi, logic [7:0] d, bit endp = 0);
    @(negedge clk);
    wr_en = 1; wr_addr = {2'(idx), hi}; wr_data = d; cycle_end = endp;
    @(negedge clk);
    wr_en = 0; cycle_end = 0;
  endtask

  task automatic pulse();
    @(negedge clk); cycle_end = 1;
    @(negedge clk); cycle_end = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 sa", act_sa, 0); chk("R1 ra", act_ra, 0);
    chk("R1 sb", act_sb, 0); chk("R1 rb", act_rb, 0);
  endtask

  task automatic t_unlocked();
    wr(3, 1, 8'h12); wr(3, 0, 8'h34); wr(0, 1, 8'hAB); wr(0, 0, 8'hCD);
    idle(1);
    chk("R3 rb follows", act_rb, 16'h1234);
    chk("R2 sa bytes", act_sa, 16'hABCD);
    wr(3, 1, 8'h56); idle(1);
    chk("R2 high byte only", act_rb, 16'h5634);
    pulse();
    chk("R3 cycle_end no effect", act_rb, 16'h5634);
  endtask

  task automatic t_lock();
    hold = 1;
    wr(0, 1, 8'h11); wr(0, 0, 8'h11); pulse(); idle(2);
    chk("R4 frozen", act_sa, 16'hABCD);
    hold = 0; idle(1);
    chk("R4 release", act_sa, 16'h1111);
  endtask

  task automatic t_auto();
    auto_mode = 1;
    wr(2, 1, 8'h22); wr(2, 0, 8'h22); pulse();
    chk("R5 not armed", act_sb, 16'h0000);
    wr(3, 0, 8'h77); idle(3);
    chk("R7 no strobe", act_rb, 16'h5634);
    hold = 1; pulse();
    chk("R7 hold ignored sb", act_sb, 16'h2222);
    chk("R5 copy rb", act_rb, 16'h5677);
    wr(3, 1, 8'h99); pulse();
    chk("R6 no repeat", act_rb, 16'h5677);
    wr(3, 0, 8'h00); wr(1, 1, 8'h33); wr(1, 0, 8'h33); pulse();
    chk("R5 disarmed by RA", act_rb, 16'h5677);
    chk("R5 disarmed ra", act_ra, 16'h0000);
    hold = 0;
  endtask

  task automatic t_coincide();
    wr(3, 0, 8'h01);
    wr(3, 0, 8'h02, 1);
    chk("R9 armed old rb", act_rb, 16'h9901);
    chk("R9 armed ra", act_ra, 16'h3333);
    pulse();
    chk("R9 rearmed", act_rb, 16'h9902);
    wr(3, 0, 8'h03, 1);
    chk("R9 unarmed", act_rb, 16'h9902);
    pulse();
    chk("R9 next end", act_rb, 16'h9903);
  endtask

  task automatic t_fifty();
    auto_mode = 0; fifty = 1; idle(2);
    chk("R8 sa mirror", act_sa, 16'h2222);
    chk("R8 ra mirror", act_ra, 16'h9903);
    wr(0, 1, 8'h44); wr(0, 0, 8'h44); idle(1);
    chk("R8 sa write ignored", act_sa, 16'h2222);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    idle(1);
    t_reset();
    t_unlocked();
    t_lock();
    t_auto();
    t_coincide();
    t_fifty();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule